// File: doc/BRIEF.md
# Linked-Load / Conditional-Store Reservation Monitor

This block tracks one reservation for a core that builds atomic read-modify-write sequences from a linked doubleword load followed by a conditional doubleword store. The linked load records the cache line it touched. Any write to that line that the monitor observes before the conditional store cancels the reservation. Such a write can be an ordinary store from the same core or a write snooped from another agent. The conditional store is then granted or refused, and the result is reported as a flag. The bus is never stalled or locked.

The monitor sees one request per cycle from the core's load/store pipe. It also sees a set of snoop ports, each carrying a valid bit and a line address, and a pulse for the return from an exception. It moves no data and holds no cache state. Its verdict is the write permission that the store path applies to the conditional store. Every response is registered and appears one clock edge after the request.

Top module: `llsc_resv_monitor`

## Requirements
- R1: A request with `req_op` = 2'b01 (linked load) and the low three address bits zero records a reservation on the line `req_addr >> log2(LINE_BYTES)`. `resv_valid` reads 1 after the next edge.
- R2: A request with `req_op` = 2'b10 (conditional store) and an aligned address in the reserved line, with no write to that line since the linked load, gives `sc_done` = 1 and `sc_ok` = 1 after the next edge. This holds for any aligned offset in the line.
- R3: An aligned conditional store to any line other than the reserved one gives `sc_done` = 1 and `sc_ok` = 0, even while a reservation is held.
- R4: Every aligned conditional store clears the reservation, whether it succeeds or fails. A second conditional store with no new linked load therefore fails.
- R5: A request with `req_op` = 2'b11 (ordinary store) to any byte of the reserved line clears the reservation. An ordinary store to another line leaves it intact.
- R6: A valid write on any snoop port whose line equals the reserved line clears the reservation. Snoops to other lines leave it intact.
- R7: When a snooped write to the reserved line arrives in the same cycle as a conditional store to that line, the snoop wins and `sc_ok` = 0.
- R8: A pulse on `exc_ret` clears the reservation. A conditional store in the same cycle as that pulse fails.
- R9: A linked load or conditional store whose address has any of its low three bits set gives `addr_err` = 1 for one cycle after the next edge and `sc_done` = 0. It leaves the reservation unchanged.
- R10: A conditional store with no reservation held fails (`sc_done` = 1, `sc_ok` = 0).
- R11: A linked load while a reservation is held moves the reservation to the new line. A conditional store to the old line then fails.
- R12: A linked load accompanied in the same cycle by a snooped write to its own line, or by `exc_ret`, records no reservation.
- R13: While `rst_n` is low, and on the first cycle after it rises, `resv_valid`, `sc_done`, `sc_ok` and `addr_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_op | input | 2 | 00 idle, 01 linked load, 10 conditional store, 11 ordinary store |
| req_addr | input | ADDR_W | Byte address of the request |
| snp_valid | input | NUM_SNP | One valid bit per snoop port |
| snp_line | input | NUM_SNP*(ADDR_W-log2(LINE_BYTES)) | Line address of each snooped write, port 0 in the low slice |
| exc_ret | input | 1 | Pulse marking a return from an exception |
| sc_done | output | 1 | A conditional store was judged |
| sc_ok | output | 1 | The conditional store may write |
| addr_err | output | 1 | A linked or conditional access was misaligned |
| resv_valid | output | 1 | A reservation is currently held |

## Verification
Every result of this monitor is due exactly one rising edge after the request, snoop or exception pulse that caused it. This covers the verdict of a conditional store, the alignment error and the change in `resv_valid`. The bench drives each stimulus just after an edge, waits for the next edge and samples one nanosecond later. Each check therefore reads the response to the stimulus just applied and nothing older. Same-cycle collisions are built by presenting the snoop or exception pulse in the very cycle of the store or load it must override.

// File: rtl/llsc_resv_pkg.sv
package llsc_resv_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_LINK = 2'b01,
      OP_COND = 2'b10,
      OP_PLAIN = 2'b11
   } llsc_op_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/llsc_align_chk.sv
module llsc_align_chk #(
   parameter int OFF_W        = 5,
   parameter int ACCESS_BYTES = 8
) (
   input  logic [OFF_W-1:0] offset_i,
   output logic             aligned_o
);
   localparam logic [OFF_W-1:0] ALIGN_MASK = OFF_W'(ACCESS_BYTES - 1);

   always_comb begin
      aligned_o = ((offset_i & ALIGN_MASK) == '0);
   end
endmodule

// File: rtl/llsc_line_match.sv
module llsc_line_match #(
   parameter int TAG_W = 43
) (
   input  logic             en_i,
   input  logic [TAG_W-1:0] tag_a_i,
   input  logic [TAG_W-1:0] tag_b_i,
   output logic             hit_o
);
   always_comb begin
      hit_o = en_i && (tag_a_i == tag_b_i);
   end
endmodule

// File: rtl/llsc_snoop_hit.sv
module llsc_snoop_hit #(
   parameter int TAG_W   = 43,
   parameter int NUM_SNP = 2
) (
   input  logic [NUM_SNP-1:0]       snp_valid_i,
   input  logic [NUM_SNP*TAG_W-1:0] snp_line_i,
   input  logic [TAG_W-1:0]         tag_i,
   output logic                     hit_o
);
   logic [NUM_SNP-1:0] port_hit;

   for (genvar g = 0; g < NUM_SNP; g++) begin : g_port
      llsc_line_match #(.TAG_W(TAG_W)) u_match (
         .en_i    (snp_valid_i[g]),
         .tag_a_i (snp_line_i[g*TAG_W +: TAG_W]),
         .tag_b_i (tag_i),
         .hit_o   (port_hit[g])
      );
   end

   always_comb begin
      hit_o = |port_hit;
   end
endmodule

// File: rtl/llsc_resv_state.sv
module llsc_resv_state #(
   parameter int TAG_W = 43
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic [TAG_W-1:0] set_tag_i,
   input  logic             kill_i,
   output logic             valid_o,
   output logic [TAG_W-1:0] tag_o
);
   logic             valid_q;
   logic [TAG_W-1:0] tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
      end else if (set_i) begin
         valid_q <= 1'b1;
         tag_q   <= set_tag_i;
      end else if (kill_i) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o = valid_q;
   assign tag_o   = tag_q;
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
   parameter int ADDR_W       = 48,
   parameter int LINE_BYTES   = 32,
   parameter int ACCESS_BYTES = 8,
   parameter int NUM_SNP      = 2
) (
   input  logic                                                clk,
   input  logic                                                rst_n,
   input  logic [1:0]                                          req_op,
   input  logic [ADDR_W-1:0]                                   req_addr,
   input  logic [NUM_SNP-1:0]                                  snp_valid,
   input  logic [NUM_SNP*(ADDR_W-$clog2(LINE_BYTES))-1:0]      snp_line,
   input  logic                                                exc_ret,
   output logic                                                sc_done,
   output logic                                                sc_ok,
   output logic                                                addr_err,
   output logic                                                resv_valid
);
   import llsc_resv_pkg::*;

   localparam int LINE_LSB = $clog2(LINE_BYTES);
   localparam int TAG_W    = ADDR_W - LINE_LSB;

   // Elaboration-time parameter checks
   if (!is_pow2(LINE_BYTES)) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (!is_pow2(ACCESS_BYTES) || ACCESS_BYTES > LINE_BYTES) begin : g_bad_access
      $error("ACCESS_BYTES must be a power of two not above LINE_BYTES");
   end
   if (LINE_LSB < 1 || TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed log2(LINE_BYTES), line at least 2 bytes");
   end
   if (NUM_SNP < 1) begin : g_bad_snp
      $error("NUM_SNP must be at least one");
   end

   llsc_op_e         op;
   logic [TAG_W-1:0] req_tag;
   logic [TAG_W-1:0] resv_tag;
   logic             resv_q;
   logic             aligned;
   logic             req_in_resv;
   logic             snp_on_resv;
   logic             snp_on_req;
   logic             link_go, cond_go, misaligned, plain_st;
   logic             set_resv, kill_resv, cond_pass;
   logic             done_q, ok_q, err_q;

   assign op      = llsc_op_e'(req_op);
   assign req_tag = req_addr[ADDR_W-1:LINE_LSB];

   llsc_align_chk #(.OFF_W(LINE_LSB), .ACCESS_BYTES(ACCESS_BYTES)) u_align (
      .offset_i  (req_addr[LINE_LSB-1:0]),
      .aligned_o (aligned)
   );

   llsc_line_match #(.TAG_W(TAG_W)) u_req_match (
      .en_i    (resv_q),
      .tag_a_i (req_tag),
      .tag_b_i (resv_tag),
      .hit_o   (req_in_resv)
   );

   llsc_snoop_hit #(.TAG_W(TAG_W), .NUM_SNP(NUM_SNP)) u_snp_resv (
      .snp_valid_i (snp_valid),
      .snp_line_i  (snp_line),
      .tag_i       (resv_tag),
      .hit_o       (snp_on_resv)
   );

   llsc_snoop_hit #(.TAG_W(TAG_W), .NUM_SNP(NUM_SNP)) u_snp_req (
      .snp_valid_i (snp_valid),
      .snp_line_i  (snp_line),
      .tag_i       (req_tag),
      .hit_o       (snp_on_req)
   );

   always_comb begin
      link_go    = (op == OP_LINK) && aligned;
      cond_go    = (op == OP_COND) && aligned;
      misaligned = ((op == OP_LINK) || (op == OP_COND)) && !aligned;
      plain_st   = (op == OP_PLAIN);
      // A new link is refused when its own line is written or an exception returns
      set_resv   = link_go && !exc_ret && !snp_on_req;
      // Any observed write to the reserved line, any judged store, any exception return
      kill_resv  = exc_ret || (snp_valid != '0 && snp_on_resv)
                   || (plain_st && req_in_resv) || cond_go;
      // Snoop and exception return take precedence over a same-cycle store
      cond_pass  = cond_go && req_in_resv && !snp_on_resv && !exc_ret;
   end

   llsc_resv_state #(.TAG_W(TAG_W)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_resv),
      .set_tag_i (req_tag),
      .kill_i    (kill_resv),
      .valid_o   (resv_q),
      .tag_o     (resv_tag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ok_q   <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= cond_go;
         ok_q   <= cond_pass;
         err_q  <= misaligned;
      end
   end

   assign sc_done    = done_q;
   assign sc_ok      = ok_q;
   assign addr_err   = err_q;
   assign resv_valid = resv_q;

   AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      sc_ok |-> sc_done); // R2
   AST_OK_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
      sc_ok |-> $past(resv_valid)); // R10
   AST_COND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      sc_done |-> !resv_valid); // R4
   AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !(sc_done && addr_err)); // R9
   AST_ERR_KEEPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_err && !$past(exc_ret) && ($past(snp_valid) == '0)) |-> $stable(resv_valid)); // R9
   AST_ERET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      exc_ret |=> !resv_valid); // R8
   AST_ERET_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      exc_ret |=> !sc_ok); // R8
endmodule

// File: tb/llsc_resv_monitor_bench.sv
`timescale 1ns/1ps
module llsc_resv_monitor_bench;
   localparam int AW = 12;
   localparam int LB = 32;
   localparam int NS = 2;
   localparam int TW = AW - 5;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n;
   logic [1:0]       req_op;
   logic [AW-1:0]    req_addr;
   logic [NS-1:0]    snp_valid;
   logic [NS*TW-1:0] snp_line;
   logic             exc_ret;
   logic             sc_done, sc_ok, addr_err, resv_valid;

   int n_chk  = 0;
   int n_fail = 0;

   llsc_resv_monitor #(.ADDR_W(AW), .LINE_BYTES(LB), .ACCESS_BYTES(8), .NUM_SNP(NS)) u_llsc_resv_monitor (
      .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
      .snp_valid(snp_valid), .snp_line(snp_line), .exc_ret(exc_ret),
      .sc_done(sc_done), .sc_ok(sc_ok), .addr_err(addr_err), .resv_valid(resv_valid)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] mk(input int line, input int off);
      return AW'(line * LB + off);
   endfunction

   task automatic step(input logic [1:0] op, input logic [AW-1:0] a, input logic [NS-1:0] sv,
                       input logic [TW-1:0] l0, input logic [TW-1:0] l1, input logic er);
      req_op = op; req_addr = a; snp_valid = sv; snp_line = {l1, l0}; exc_ret = er;
      @(posedge clk); #1;
      req_op = 2'b00; snp_valid = '0; exc_ret = 1'b0;
   endtask

   task automatic ll(input logic [AW-1:0] a); step(2'b01, a, '0, '0, '0, 1'b0); endtask
   task automatic sc(input logic [AW-1:0] a); step(2'b10, a, '0, '0, '0, 1'b0); endtask
   task automatic st(input logic [AW-1:0] a); step(2'b11, a, '0, '0, '0, 1'b0); endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      finish_up();
   end

   initial begin
      rst_n = 1'b0; req_op = 2'b00; req_addr = '0; snp_valid = '0; snp_line = '0; exc_ret = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R13 reset resv", resv_valid, 0);
      check("R13 reset done", sc_done, 0);
      check("R13 reset ok", sc_ok, 0);
      check("R13 reset err", addr_err, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R13 first cycle resv", resv_valid, 0);
      check("R13 first cycle done", sc_done, 0);

      // R10: conditional store with nothing reserved
      sc(mk(3, 8));
      check("R10 done", sc_done, 1);
      check("R10 ok", sc_ok, 0);

      // R1 R2 R3 R4: sweep of link line/offset against store line/offset
      for (int l = 0; l < 8; l++)
         for (int o = 0; o < LB; o += 8)
            for (int p = 0; p < 8; p++)
               for (int q = 0; q < LB; q += 8) begin
                  ll(mk(l * 18, o));
                  check("R1 link sets", resv_valid, 1);
                  check("R1 link no result", sc_done, 0);
                  sc(mk(p * 18, q));
                  check("R2 done", sc_done, 1);
                  if (p == l) check("R2 same line ok", sc_ok, 1);
                  else        check("R3 other line ok", sc_ok, 0);
                  check("R4 cleared", resv_valid, 0);
               end

      // R4: second store without relink
      ll(mk(9, 0)); sc(mk(9, 0));
      check("R4 first ok", sc_ok, 1);
      sc(mk(9, 0));
      check("R4 second ok", sc_ok, 0);

      // R5: plain stores at every byte of the line, and to another line
      for (int b = 0; b < LB; b++) begin
         ll(mk(5, 16));
         st(mk(5, b));
         check("R5 store same line clears", resv_valid, 0);
         sc(mk(5, 16));
         check("R5 store same line fails", sc_ok, 0);
         ll(mk(5, 16));
         st(mk(6, b));
         check("R5 store other line keeps", resv_valid, 1);
         sc(mk(5, 16));
         check("R5 store other line ok", sc_ok, 1);
      end

      // R6: snoops on each port
      for (int pt = 0; pt < NS; pt++) begin
         ll(mk(40, 0));
         step(2'b00, '0, NS'(1 << pt), TW'(40), TW'(40), 1'b0);
         check("R6 snoop hit clears", resv_valid, 0);
         ll(mk(40, 0));
         step(2'b00, '0, NS'(1 << pt), TW'(41), TW'(39), 1'b0);
         check("R6 snoop miss keeps", resv_valid, 1);
         sc(mk(40, 24));
         check("R6 snoop miss ok", sc_ok, 1);
      end

      // R7: snoop collides with conditional store
      for (int pt = 0; pt < NS; pt++) begin
         ll(mk(77, 8));
         step(2'b10, mk(77, 8), NS'(1 << pt), TW'(77), TW'(77), 1'b0);
         check("R7 collide done", sc_done, 1);
         check("R7 collide ok", sc_ok, 0);
         ll(mk(77, 8));
         step(2'b10, mk(77, 8), NS'(1 << pt), TW'(78), TW'(78), 1'b0);
         check("R7 other line ok", sc_ok, 1);
      end

      // R8: exception return
      ll(mk(12, 0));
      step(2'b00, '0, '0, '0, '0, 1'b1);
      check("R8 eret clears", resv_valid, 0);
      sc(mk(12, 0));
      check("R8 after eret fails", sc_ok, 0);
      ll(mk(12, 0));
      step(2'b10, mk(12, 0), '0, '0, '0, 1'b1);
      check("R8 same cycle done", sc_done, 1);
      check("R8 same cycle fails", sc_ok, 0);

      // R9: misaligned linked and conditional accesses
      for (int m = 1; m < 8; m++) begin
         ll(mk(2, 8));
         sc(mk(2, 8 + m));
         check("R9 cond err", addr_err, 1);
         check("R9 cond no done", sc_done, 0);
         check("R9 cond keeps resv", resv_valid, 1);
         ll(mk(50, m));
         check("R9 link err", addr_err, 1);
         check("R9 link keeps resv", resv_valid, 1);
         step(2'b00, '0, '0, '0, '0, 1'b0);
         check("R9 err one cycle", addr_err, 0);
         sc(mk(2, 0));
         check("R9 original line ok", sc_ok, 1);
         ll(mk(50, m));
         check("R9 link none held", resv_valid, 0);
      end

      // R11: relink moves the reservation
      ll(mk(1, 0)); ll(mk(6, 0)); sc(mk(1, 0));
      check("R11 old line fails", sc_ok, 0);
      ll(mk(1, 0)); ll(mk(6, 0)); sc(mk(6, 8));
      check("R11 new line ok", sc_ok, 1);

      // R12: link refused by same-cycle snoop or eret
      step(2'b01, mk(20, 0), 2'b10, TW'(0), TW'(20), 1'b0);
      check("R12 snoop refuses link", resv_valid, 0);
      step(2'b01, mk(20, 0), 2'b01, TW'(21), TW'(0), 1'b0);
      check("R12 snoop elsewhere link ok", resv_valid, 1);
      sc(mk(20, 0));
      step(2'b01, mk(20, 0), '0, '0, '0, 1'b1);
      check("R12 eret refuses link", resv_valid, 0);

      finish_up();
   end
endmodule